// File: doc/BRIEF.md
# Two-Stage Timebase Watchdog

This block is a watchdog that sits on a plain 32-bit register port, with a write strobe, an address, write data and a read-data path decoded directly from the address. A free-running timebase counter starts at zero after reset and steps once per clock. Software can read it to confirm that the clock is alive. The watchdog interval logic counts periods of 2^N clocks. It runs only while two enable bits are both 1, and those bits live in two different registers.

When an interval ends for the first time, the block sets a warning flag, and the interrupt output goes high. If software does not clear that flag and a second interval ends, the block sets a sticky reset-status flag and drives a system reset pulse of fixed length. Software services the watchdog by writing 1 to a flag bit. That write clears the flag and also restarts the current interval. As a build-time option, an enable-once lock stops the watchdog from being switched off after it has first been armed.

Internally, a three-state controller owns the interval. Its states are IDLE (disarmed), RUN (armed and counting) and BITE (reset pulse in progress). Its transitions are:
- arm: IDLE to RUN, when both enables are 1.
- disarm: RUN to IDLE, when either enable drops.
- bite: RUN or IDLE to BITE, on an expiry while the warning flag is already set.
- release: BITE back to RUN or IDLE once the pulse is done, chosen by the enables.

A first expiry is a "warn" event and does not change state.

Top module: `tbase_wdog`

## Requirements
- R1: After reset, every register reads 0, including the timebase, and `wdog_irq` and `wdog_rst` are 0.
- R2: Register words are selected by `bus_addr[3:2]`. Word 0 is control 0: bit 3 is the reset-status flag, bit 2 is the warning flag, bit 1 is enable A, and bit 0 reads back enable B. Word 1 is control 1, with enable B at bit 0. Word 2 is the timebase count. Word 3 reads 0. Unused bits read 0.
- R3: The interval counts only while enable A and enable B are both 1. While either is 0 the interval is held at its start, and no flag can be set.
- R4: While both enables are set, the first expiry comes 2^N clocks after counting begins and sets the warning flag. `wdog_irq` is high exactly while the warning flag and both enables are 1.
- R5: An expiry while the warning flag is already 1 sets the reset-status flag and drives `wdog_rst` high for exactly RST_PULSE_CYC clocks. Counting then resumes from the start, and the warning flag stays set.
- R6: Writing 1 to control 0 bit 3 or bit 2 clears that flag, and either one restarts the interval. Writing 0 to those bits leaves the flags unchanged, so rewriting enable A with zeros in bits 3:2 keeps the flags as they were.
- R7: A keepalive write in the same clock as an expiry wins. No flag is set, and the interval restarts.
- R8: The timebase increases by exactly 1 on every clock after reset.
- R9: With ENABLE_ONCE=1, once both enables have been 1 together, writes of 0 to enable A or enable B are ignored. With ENABLE_ONCE=0 such writes clear them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_addr | input | ADDR_W | Byte address; bits 3:2 select the word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed word |
| wdog_irq | output | 1 | Warning interrupt, level |
| wdog_rst | output | 1 | System reset pulse |

## Verification
A keepalive write and an interval expiry can fall in the same clock. The bench provokes this by watching its reference model's interval count and issuing a flag-clearing write in exactly the clock where that count is at its last value. The result is judged correct when the warning flag reads back 0 afterwards and the interrupt stays low. The reset pulse and the release into RUN are also compared every clock against the model, on two instances that differ only in the enable-once option.

// File: rtl/twdog_pkg.sv
package twdog_pkg;

    typedef enum logic [1:0] {
        WD_IDLE = 2'd0,
        WD_RUN  = 2'd1,
        WD_BITE = 2'd2
    } wd_state_e;

    // word selects (bus_addr[3:2])
    localparam int unsigned SEL_CTRL0 = 0;
    localparam int unsigned SEL_CTRL1 = 1;
    localparam int unsigned SEL_TBASE = 2;

    // control 0 field positions
    localparam int unsigned BIT_RSTF = 3;
    localparam int unsigned BIT_WARN = 2;
    localparam int unsigned BIT_ENA  = 1;
    // control 1 field position
    localparam int unsigned BIT_ENB  = 0;

endpackage

// File: rtl/tbase_wdog_timebase.sv
module tbase_wdog_timebase #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [WIDTH-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/tbase_wdog_regs.sv
module tbase_wdog_regs
    import twdog_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 4,
    parameter bit          ENABLE_ONCE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] tb_count,
    input  logic              set_wds,
    input  logic              set_wrs,
    output logic [DATA_W-1:0] rdata,
    output logic              en_a_q,
    output logic              en_b_q,
    output logic              en_both,
    output logic              wds_q,
    output logic              wrs_q,
    output logic              kick,
    output logic              locked
);

    localparam int unsigned SEL_W = ADDR_W - 2;

    logic [SEL_W-1:0] sel;
    logic             wr_ctrl0;
    logic             wr_ctrl1;
    logic             clr_wds;
    logic             clr_wrs;
    logic             unused_bits;

    assign sel         = bus_addr[ADDR_W-1:2];
    assign wr_ctrl0    = bus_wr && (sel == SEL_W'(SEL_CTRL0));
    assign wr_ctrl1    = bus_wr && (sel == SEL_W'(SEL_CTRL1));
    assign clr_wds     = wr_ctrl0 && bus_wdata[BIT_WARN];
    assign clr_wrs     = wr_ctrl0 && bus_wdata[BIT_RSTF];
    assign kick        = clr_wds || clr_wrs;
    assign en_both     = en_a_q && en_b_q;
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:4]};

    // enable-once variant: a sticky arm record blocks disabling writes
    generate
        if (ENABLE_ONCE) begin : g_lock
            logic armed_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    armed_q <= 1'b0;
                end else if (en_both) begin
                    armed_q <= 1'b1;
                end
            end
            assign locked = armed_q || en_both;
        end else begin : g_nolock
            assign locked = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_a_q <= 1'b0;
            en_b_q <= 1'b0;
        end else begin
            if (wr_ctrl0 && !(locked && !bus_wdata[BIT_ENA])) begin
                en_a_q <= bus_wdata[BIT_ENA];
            end
            if (wr_ctrl1 && !(locked && !bus_wdata[BIT_ENB])) begin
                en_b_q <= bus_wdata[BIT_ENB];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wds_q <= 1'b0;
            wrs_q <= 1'b0;
        end else begin
            wds_q <= (wds_q && !clr_wds) || set_wds;
            wrs_q <= (wrs_q && !clr_wrs) || set_wrs;
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_W'(SEL_CTRL0): begin
                rdata[BIT_RSTF] = wrs_q;
                rdata[BIT_WARN] = wds_q;
                rdata[BIT_ENA]  = en_a_q;
                rdata[0]        = en_b_q;
            end
            SEL_W'(SEL_CTRL1): rdata[BIT_ENB] = en_b_q;
            SEL_W'(SEL_TBASE): rdata = tb_count;
            default:           rdata = '0;
        endcase
    end

endmodule

// File: rtl/tbase_wdog_fsm.sv
module tbase_wdog_fsm
    import twdog_pkg::*;
#(
    parameter int unsigned INTERVAL_LOG2 = 8,
    parameter int unsigned RST_PULSE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_both,
    input  logic kick,
    input  logic wds_flag,
    output logic set_wds,
    output logic set_wrs,
    output logic wdog_rst
);

    localparam int unsigned PC_W = (RST_PULSE_CYC > 1) ? $clog2(RST_PULSE_CYC) : 1;
    localparam logic [INTERVAL_LOG2-1:0] IVAL_LAST = '1;
    localparam logic [PC_W-1:0]          PC_LAST   = PC_W'(RST_PULSE_CYC - 1);

    wd_state_e               state_q;
    wd_state_e               state_d;
    logic [INTERVAL_LOG2-1:0] ival_q;
    logic [PC_W-1:0]          pc_q;
    logic                     expire;
    logic                     pulse_done;

    // a keepalive in the expiry cycle cancels the expiry
    assign expire     = (state_q != WD_BITE) && en_both && (ival_q == IVAL_LAST) && !kick;
    assign pulse_done = (state_q == WD_BITE) && (pc_q == PC_LAST);
    assign set_wds    = expire && !wds_flag;
    assign set_wrs    = expire && wds_flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE: begin
                if (set_wrs) begin
                    state_d = WD_BITE;
                end else if (en_both) begin
                    state_d = WD_RUN;
                end
            end
            WD_RUN: begin
                if (set_wrs) begin
                    state_d = WD_BITE;
                end else if (!en_both) begin
                    state_d = WD_IDLE;
                end
            end
            WD_BITE: begin
                if (pulse_done) begin
                    state_d = en_both ? WD_RUN : WD_IDLE;
                end
            end
            default: state_d = WD_IDLE;
        endcase
    end

    always_comb begin
        wdog_rst = (state_q == WD_BITE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ival_q <= '0;
        end else if (state_q == WD_BITE || !en_both || kick || expire) begin
            ival_q <= '0;
        end else begin
            ival_q <= ival_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (state_q == WD_BITE) begin
            pc_q <= pulse_done ? '0 : pc_q + 1'b1;
        end else begin
            pc_q <= '0;
        end
    end

endmodule

// File: rtl/tbase_wdog.sv
module tbase_wdog
    import twdog_pkg::*;
#(
    parameter int unsigned DATA_W        = 32,
    parameter int unsigned ADDR_W        = 4,
    parameter int unsigned INTERVAL_LOG2 = 8,
    parameter int unsigned RST_PULSE_CYC = 4,
    parameter bit          ENABLE_ONCE   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdog_irq,
    output logic              wdog_rst
);

    logic [DATA_W-1:0] tb_count;
    logic              en_a_q;
    logic              en_b_q;
    logic              en_both;
    logic              wds_q;
    logic              wrs_q;
    logic              kick;
    logic              locked;
    logic              set_wds;
    logic              set_wrs;

    tbase_wdog_timebase #(.WIDTH(DATA_W)) u_tbase (
        .clk   (clk),
        .rst_n (rst_n),
        .count (tb_count)
    );

    tbase_wdog_regs #(
        .DATA_W      (DATA_W),
        .ADDR_W      (ADDR_W),
        .ENABLE_ONCE (ENABLE_ONCE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .tb_count  (tb_count),
        .set_wds   (set_wds),
        .set_wrs   (set_wrs),
        .rdata     (bus_rdata),
        .en_a_q    (en_a_q),
        .en_b_q    (en_b_q),
        .en_both   (en_both),
        .wds_q     (wds_q),
        .wrs_q     (wrs_q),
        .kick      (kick),
        .locked    (locked)
    );

    tbase_wdog_fsm #(
        .INTERVAL_LOG2 (INTERVAL_LOG2),
        .RST_PULSE_CYC (RST_PULSE_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_both  (en_both),
        .kick     (kick),
        .wds_flag (wds_q),
        .set_wds  (set_wds),
        .set_wrs  (set_wrs),
        .wdog_rst (wdog_rst)
    );

    assign wdog_irq = wds_q && en_both;

endmodule

// File: rtl/tbase_wdog_chk.sv
module tbase_wdog_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_ctrl0,
    input logic              wd_warn,
    input logic              wds_q,
    input logic              wrs_q,
    input logic              en_a_q,
    input logic              en_both,
    input logic              locked,
    input logic [DATA_W-1:0] tb_count,
    input logic              wdog_rst
);

    // R3: no warning can appear while disarmed
    p_no_warn_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_both && !wds_q) |=> !wds_q);

    // R4: a warning only follows a cycle with both enables set
    p_warn_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wds_q) |-> $past(en_both));

    // R5: the reset pulse starts only after a warning and records status
    p_bite_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdog_rst) |-> (wrs_q && $past(wds_q)));

    // R6: writing 1 to the warning bit leaves it clear
    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl0 && wd_warn) |=> !wds_q);

    // R6: writing 0 to the warning bit keeps it
    p_zero_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl0 && !wd_warn && wds_q) |=> wds_q);

    // R8: timebase steps by one each clock after reset
    p_tb_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (tb_count == $past(tb_count) + 1'b1));

    // R9: a locked enable cannot fall
    p_lock_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && en_a_q) |=> en_a_q);

endmodule

bind tbase_wdog tbase_wdog_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctrl0 (bus_wr && (bus_addr[ADDR_W-1:2] == '0)),
    .wd_warn  (bus_wdata[2]),
    .wds_q    (wds_q),
    .wrs_q    (wrs_q),
    .en_a_q   (en_a_q),
    .en_both  (en_both),
    .locked   (locked),
    .tb_count (tb_count),
    .wdog_rst (wdog_rst)
);

// File: tb/tbase_wdog_tb_top.sv
module tbase_wdog_tb_top;

    localparam int N    = 5;
    localparam int P    = 3;
    localparam int DW   = 32;
    localparam int AW   = 4;
    localparam int MAXC = (1 << N) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] rdata [2];
    logic          irq [2];
    logic          rstw [2];

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tbase_wdog #(.DATA_W(DW), .ADDR_W(AW), .INTERVAL_LOG2(N),
                 .RST_PULSE_CYC(P), .ENABLE_ONCE(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata[0]), .wdog_irq(irq[0]),
        .wdog_rst(rstw[0]));

    tbase_wdog #(.DATA_W(DW), .ADDR_W(AW), .INTERVAL_LOG2(N),
                 .RST_PULSE_CYC(P), .ENABLE_ONCE(1'b1)) dut_lock_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata[1]), .wdog_irq(irq[1]),
        .wdog_rst(rstw[1]));

    // behavioural reference model, index 1 has the enable-once lock
    bit          m_ena [2];
    bit          m_enb [2];
    bit          m_wds [2];
    bit          m_wrs [2];
    bit          m_arm [2];
    bit          m_bite [2];
    int          m_cnt [2];
    int          m_pc [2];
    logic [31:0] m_tb = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tb = '0;
            for (int k = 0; k < 2; k++) begin
                m_ena[k] = 0; m_enb[k] = 0; m_wds[k] = 0; m_wrs[k] = 0;
                m_arm[k] = 0; m_bite[k] = 0; m_cnt[k] = 0; m_pc[k] = 0;
            end
        end else begin
            m_tb = m_tb + 1;
            for (int k = 0; k < 2; k++) begin
                bit eb, lkd, w0, w1, kk, ex, nw, nr;
                eb  = m_ena[k] && m_enb[k];
                lkd = (k == 1) && (m_arm[k] || eb);
                w0  = bus_wr && (bus_addr[3:2] == 2'd0);
                w1  = bus_wr && (bus_addr[3:2] == 2'd1);
                kk  = w0 && (bus_wdata[2] || bus_wdata[3]);
                ex  = !m_bite[k] && eb && (m_cnt[k] == MAXC) && !kk;
                nw  = (m_wds[k] && !(w0 && bus_wdata[2])) || (ex && !m_wds[k]);
                nr  = (m_wrs[k] && !(w0 && bus_wdata[3])) || (ex && m_wds[k]);
                if (m_bite[k]) begin
                    m_cnt[k] = 0;
                    if (m_pc[k] == P - 1) begin
                        m_bite[k] = 0; m_pc[k] = 0;
                    end else begin
                        m_pc[k] = m_pc[k] + 1;
                    end
                end else if (ex && m_wds[k]) begin
                    m_bite[k] = 1; m_pc[k] = 0; m_cnt[k] = 0;
                end else if (!eb || kk || ex) begin
                    m_cnt[k] = 0;
                end else begin
                    m_cnt[k] = m_cnt[k] + 1;
                end
                m_wds[k] = nw;
                m_wrs[k] = nr;
                if (w0 && !(lkd && !bus_wdata[1])) m_ena[k] = bus_wdata[1];
                if (w1 && !(lkd && !bus_wdata[0])) m_enb[k] = bus_wdata[0];
                m_arm[k] = m_arm[k] || eb;
            end
        end
    end

    function automatic logic [31:0] exp_rd(int k);
        case (bus_addr[3:2])
            2'd0:    return {28'b0, m_wrs[k], m_wds[k], m_ena[k], m_enb[k]};
            2'd1:    return {31'b0, m_enb[k]};
            2'd2:    return m_tb;
            default: return 32'b0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-clock comparison, sampled 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (!done) begin
            for (int k = 0; k < 2; k++) begin
                chk("R2 bus_rdata vs model", rdata[k], exp_rd(k));
                chk("R4 wdog_irq vs model", {31'b0, irq[k]},
                    {31'b0, m_wds[k] && m_ena[k] && m_enb[k]});
                chk("R5 wdog_rst vs model", {31'b0, rstw[k]}, {31'b0, m_bite[k]});
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        int n;
        logic [31:0] t1, t2;
        // R1: reset values while reset is held
        rd(4'h0); chk("R1 ctrl0 at reset", rdata[0], 32'h0);
        rd(4'h4); chk("R1 ctrl1 at reset", rdata[0], 32'h0);
        rd(4'h8); chk("R1 timebase at reset", rdata[0], 32'h0);
        chk("R1 irq/rst at reset", {30'b0, irq[0], rstw[0]}, 32'h0);
        @(negedge clk) rst_n = 1'b1;
        // R2: unmapped word
        rd(4'hC); chk("R2 unmapped word", rdata[0], 32'h0);
        // R3: enable A alone does not count
        wr(4'h0, 32'h2);
        idle(80);
        chk("R3 irq with one enable", {31'b0, irq[0]}, 32'h0);
        rd(4'h0); chk("R3 ctrl0 one enable", rdata[0], 32'h2);
        // R4: first expiry after 2^N clocks
        wr(4'h4, 32'h1);
        n = 0;
        while (!irq[0] && n < 200) begin
            @(posedge clk); #1; n++;
        end
        chk("R4 clocks to first expiry", n, 1 << N);
        chk("R4 lock instance irq", {31'b0, irq[1]}, 32'h1);
        // R6: zero write keeps the warning flag
        wr(4'h0, 32'h2);
        rd(4'h0); chk("R6 zero write keeps flag", rdata[0], 32'h7);
        // R5: second expiry gives the reset pulse
        n = 0;
        while (!rstw[0] && n < 200) begin
            @(posedge clk); #1; n++;
        end
        n = 0;
        while (rstw[0] && n < 50) begin
            @(posedge clk); #1; n++;
        end
        chk("R5 reset pulse length", n, P);
        rd(4'h0); chk("R5 status after bite", rdata[0], 32'hF);
        // R6: write ones clears both flags
        wr(4'h0, 32'hE);
        rd(4'h0); chk("R6 w1c clears flags", rdata[0], 32'h3);
        // R7: keepalive in the expiry clock
        n = 0;
        while (m_cnt[0] != MAXC && n < 200) begin
            @(posedge clk); #1; n++;
        end
        wr(4'h0, 32'h6);
        rd(4'h0); chk("R7 keepalive beats expiry", rdata[0], 32'h3);
        chk("R7 no irq after collision", {31'b0, irq[0]}, 32'h0);
        // R9: disabling with and without the lock
        wr(4'h4, 32'h0);
        rd(4'h4);
        chk("R9 unlocked enable B cleared", rdata[0], 32'h0);
        chk("R9 locked enable B held", rdata[1], 32'h1);
        wr(4'h0, 32'h0);
        rd(4'h0);
        chk("R9 unlocked enable A cleared", rdata[0] & 32'h2, 32'h0);
        chk("R9 locked enable A held", rdata[1] & 32'h2, 32'h2);
        // R3: disarmed instance never warns
        idle(80);
        rd(4'h0); chk("R3 disarmed no warning", rdata[0], 32'h0);
        // R8: timebase steps by one
        rd(4'h8); t1 = rdata[0];
        @(posedge clk); #1; t2 = rdata[0];
        chk("R8 timebase step", t2, t1 + 1);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1-R9 run actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule